// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a supervisory counter that runs on a slow timebase. The timebase reaches it as a one-cycle `tick_i` enable in the system clock domain. Software controls it through one 8-bit control register, written with `wr_en_i`/`wr_data_i` and read back on `rd_data_o`. In watchdog mode, the counter sends a one-cycle chip-reset pulse when the selected interval runs out. Software holds off that reset by writing a two-step key within a short window. In timer mode, the same counter produces a periodic one-cycle interrupt.

While the chip sleeps (`sleep_i` high), the watchdog keeps counting but does not fire, and it wraps around at the end of the interval. When the chip wakes, a counter that is in its final timebase period fires the reset at once.

The control state machine has four states:

- `ST_OFF`: the counter is stopped.
- `ST_TIMER`: interval timer.
- `ST_WATCH`: watchdog, awake.
- `ST_NAP`: watchdog, chip asleep.

Its transitions are:

- OFF→TIMER: enable written with mode = 1.
- OFF→WATCH: enable written with mode = 0.
- TIMER→OFF: enable written as 0.
- TIMER→WATCH: enable written as 1 with mode = 0.
- WATCH→NAP: `sleep_i` rises.
- NAP→WATCH: wake when the counter is not in its final period.
- WATCH→OFF and NAP→OFF: the reset fires.

A separate key machine has two states: `KEY_IDLE` and `KEY_ARMED`. A write of 0xA moves it from idle to armed. A write of 0x5 clears the counter and returns it to idle. Any other value, or the end of the window, also returns it to idle.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset, `rd_data_o` is 0 and `irq_o` and `wdt_rst_o` are low. A read returns bits [7:4] = 0, bit 3 = enable, bit 2 = mode and bits [1:0] = interval code, so the key field always reads as 0.
- R2: The interval code selects the number of ticks per period: 00 = INTV_LONG (32768), 01 = INTV_MID (8192), 10 = INTV_SHORT (512) and 11 = INTV_TINY (64).
- R3: Writing bit 3 = 1 and bit 2 = 1 starts timer mode. `irq_o` then pulses for one cycle at each period end, and the count restarts from zero.
- R4: In timer mode, writing bit 3 = 0 stops the counter, and no further interrupts occur.
- R5: Writing bit 3 = 1 and bit 2 = 0 starts watchdog mode. At the period end, `wdt_rst_o` pulses for one cycle, and in that same cycle the register returns to 0.
- R6: In watchdog mode, writes cannot clear the enable bit or set the mode bit. The interval field can still be written.
- R7: A write of key 0xA followed by a write of 0x5 within HALF_TICK_CYCLES clocks clears the counter, which postpones the reset.
- R8: No clear happens if the 0x5 write comes later than the window, follows a write with any other key value, or has no 0xA write before it.
- R9: Key writes are ignored while the block is disabled, including the key in the very write that enables it.
- R10: While asleep in watchdog mode, no reset is sent. At the period end the counter wraps to zero and keeps counting.
- R11: Waking while the count is in its final period fires the reset on the next clock. Waking earlier does not.
- R12: `irq_o` pulses only in timer mode, `wdt_rst_o` only in watchdog mode, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timebase enable |
| sleep_i | input | 1 | High while the chip is in low-power sleep |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data: key[7:4], enable[3], mode[2], interval[1:0] |
| rd_data_o | output | 8 | Register read value |
| irq_o | output | 1 | One-cycle timer-mode interrupt |
| wdt_rst_o | output | 1 | One-cycle chip-reset request |

## Verification
The bound checker watches these rules on every clock:

- The reset pulse lasts one cycle and lands with the register already cleared.
- The watchdog never leaves its two states except by firing.
- A key clear zeroes the count.
- Sleep withholds the reset.
- The interrupt and the reset are never high together and each comes only from its own mode.

Only the bench's scenarios can show the exact period length for each interval code, and where the key window ends. They also show that a key write made while enabling is lost, that the counter wraps during sleep, and that the reset fires when the chip wakes in the final period.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_TIMER,
        ST_WATCH,
        ST_NAP
    } wdt_state_e;

    typedef enum logic {
        KEY_IDLE,
        KEY_ARMED
    } key_state_e;

    localparam logic [3:0] KEY_OPEN = 4'hA;
    localparam logic [3:0] KEY_SHUT = 4'h5;

endpackage

// File: rtl/wdt_clear_key.sv
module wdt_clear_key
    import wdt_keyed_pkg::*;
#(
    parameter int HALF_TICK_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       enabled,
    input  logic       wr_en,
    input  logic [3:0] key,
    output logic       clear_o
);

    localparam int WIN_W = $clog2(HALF_TICK_CYCLES + 1);

    key_state_e       st_q, st_d;
    logic [WIN_W-1:0] rem_q, rem_d;
    logic             wr_ok;

    assign wr_ok = wr_en && enabled;

    always_comb begin
        st_d    = st_q;
        rem_d   = rem_q;
        clear_o = 1'b0;
        unique case (st_q)
            KEY_IDLE: begin
                if (wr_ok && key == KEY_OPEN) begin
                    st_d  = KEY_ARMED;
                    rem_d = WIN_W'(HALF_TICK_CYCLES);
                end
            end
            KEY_ARMED: begin
                if (wr_ok) begin
                    if (key == KEY_SHUT) begin
                        clear_o = 1'b1;
                        st_d    = KEY_IDLE;
                    end else if (key == KEY_OPEN) begin
                        rem_d = WIN_W'(HALF_TICK_CYCLES);
                    end else begin
                        st_d = KEY_IDLE;
                    end
                end else if (rem_q == WIN_W'(1)) begin
                    st_d = KEY_IDLE;
                end else begin
                    rem_d = rem_q - WIN_W'(1);
                end
            end
        endcase
        if (flush) begin
            st_d = KEY_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= KEY_IDLE;
            rem_q <= '0;
        end else begin
            st_q  <= st_d;
            rem_q <= rem_d;
        end
    end

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             zero,
    input  logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] count_o,
    output logic             at_last_o
);

    assign at_last_o = (count_o >= last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (zero) begin
            count_o <= '0;
        end else if (run && tick) begin
            count_o <= at_last_o ? '0 : count_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_keyed_pkg::*;
#(
    parameter int INTV_LONG        = 32768,
    parameter int INTV_MID         = 8192,
    parameter int INTV_SHORT       = 512,
    parameter int INTV_TINY        = 64,
    parameter int HALF_TICK_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       sleep_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    output logic       irq_o,
    output logic       wdt_rst_o
);

    localparam int CNT_W = $clog2(INTV_LONG);

    wdt_state_e       state_q, state_d;
    logic             mode_q;
    logic [1:0]       int_q;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] count;
    logic             at_last;
    logic             key_clr;
    logic             enabled;
    logic             term_evt;
    logic             fire;

    assign enabled  = (state_q != ST_OFF);
    assign term_evt = tick_i && at_last && !key_clr;
    assign fire     = (state_q == ST_WATCH && term_evt)
                   || (state_q == ST_NAP && !sleep_i && at_last);

    always_comb begin
        unique case (int_q)
            2'b00: last = CNT_W'(INTV_LONG - 1);
            2'b01: last = CNT_W'(INTV_MID - 1);
            2'b10: last = CNT_W'(INTV_SHORT - 1);
            2'b11: last = CNT_W'(INTV_TINY - 1);
        endcase
    end

    wdt_clear_key #(
        .HALF_TICK_CYCLES(HALF_TICK_CYCLES)
    ) key_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (fire),
        .enabled(enabled),
        .wr_en  (wr_en_i),
        .key    (wr_data_i[7:4]),
        .clear_o(key_clr)
    );

    wdt_tick_counter #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enabled),
        .tick     (tick_i),
        .zero     (fire || key_clr),
        .last     (last),
        .count_o  (count),
        .at_last_o(at_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (wr_en_i && wr_data_i[3]) begin
                    state_d = wr_data_i[2] ? ST_TIMER : ST_WATCH;
                end
            end
            ST_TIMER: begin
                if (wr_en_i) begin
                    if (!wr_data_i[3]) begin
                        state_d = ST_OFF;
                    end else if (!wr_data_i[2]) begin
                        state_d = ST_WATCH;
                    end
                end
            end
            ST_WATCH: begin
                if (sleep_i) begin
                    state_d = ST_NAP;
                end
            end
            ST_NAP: begin
                if (!sleep_i) begin
                    state_d = ST_WATCH;
                end
            end
        endcase
        if (fire) begin
            state_d = ST_OFF;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Mode and interval fields
    always_ff @(posedge clk) begin
        if (!rst_n || fire) begin
            mode_q <= 1'b0;
            int_q  <= 2'b00;
        end else if (wr_en_i) begin
            int_q <= wr_data_i[1:0];
            if (state_q == ST_OFF || state_q == ST_TIMER) begin
                mode_q <= wr_data_i[2];
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            wdt_rst_o <= 1'b0;
        end else begin
            irq_o     <= (state_q == ST_TIMER) && term_evt;
            wdt_rst_o <= fire;
        end
    end

    assign rd_data_o = {4'b0000, enabled, mode_q, int_q};

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
    import wdt_keyed_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_i,
    input logic             irq_o,
    input logic             wdt_rst_o,
    input logic [7:0]       rd_data_o,
    input wdt_state_e       state_q,
    input logic [CNT_W-1:0] count,
    input logic             key_clr
);

    p_rst_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |=> !wdt_rst_o);

    p_rst_clears_regs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> (rd_data_o == 8'h00));

    p_wd_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WATCH || state_q == ST_NAP)
        |=> (wdt_rst_o || state_q == ST_WATCH || state_q == ST_NAP));

    p_key_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        key_clr |=> (count == '0));

    p_nap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NAP && sleep_i) |=> !wdt_rst_o);

    p_irq_timer_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(state_q == ST_TIMER));

    p_irq_rst_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && wdt_rst_o));

endmodule

bind wdt_keyed_top wdt_keyed_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_i  (sleep_i),
    .irq_o    (irq_o),
    .wdt_rst_o(wdt_rst_o),
    .rd_data_o(rd_data_o),
    .state_q  (state_q),
    .count    (count),
    .key_clr  (key_clr)
);

// File: tb/wdt_keyed_top_tb_top.sv
`timescale 1ns/1ps
module wdt_keyed_top_tb_top;

    localparam int L_LONG = 256, L_MID = 128, L_SHORT = 32, L_TINY = 16;
    localparam int HALF = 3, TDIV = 4;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sleep = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq, wrst;

    always #2.5 clk = ~clk;

    wdt_keyed_top #(
        .INTV_LONG(L_LONG), .INTV_MID(L_MID), .INTV_SHORT(L_SHORT),
        .INTV_TINY(L_TINY), .HALF_TICK_CYCLES(HALF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .sleep_i(sleep),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
        .irq_o(irq), .wdt_rst_o(wrst)
    );

    int    vectors = 0, miscompares = 0, cyc = 0, irq_cnt = 0, rst_cnt = 0;
    string cur_req = "R1";

    // Behavioural reference model
    bit   m_en, m_mode, m_nap, m_armed, m_irq, m_rst;
    int   m_int, m_cnt, m_rem;
    logic [7:0] exp_rd;

    function automatic int lim_of(int code);
        case (code)
            0: return L_LONG;
            1: return L_MID;
            2: return L_SHORT;
            default: return L_TINY;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int lim;
        bit term, kc, fire, wr_ok;
        logic [3:0] f;
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_en = 0; m_mode = 0; m_nap = 0; m_armed = 0; m_irq = 0; m_rst = 0;
            m_int = 0; m_cnt = 0; m_rem = 0;
        end else begin
            lim   = lim_of(m_int);
            term  = (m_cnt >= lim - 1);
            f     = wr_data[7:4];
            wr_ok = wr_en && m_en;
            kc    = wr_ok && m_armed && (f == 4'h5);
            if (wr_ok) begin
                if (f == 4'hA) begin m_armed = 1; m_rem = HALF; end
                else m_armed = 0;
            end else if (m_armed) begin
                if (m_rem == 1) m_armed = 0; else m_rem = m_rem - 1;
            end
            fire  = (m_en && !m_mode && !m_nap && tick && term && !kc)
                 || (m_nap && !sleep && term);
            m_irq = m_en && m_mode && tick && term && !kc;
            m_rst = fire;
            if (fire || kc) m_cnt = 0;
            else if (m_en && tick) m_cnt = term ? 0 : m_cnt + 1;
            if (fire) begin
                m_en = 0; m_mode = 0; m_int = 0; m_nap = 0; m_armed = 0;
            end else begin
                if (m_en && !m_mode) m_nap = sleep;
                if (wr_en) begin
                    if (m_en && !m_mode) m_int = wr_data[1:0];
                    else begin
                        m_en = wr_data[3]; m_mode = wr_data[2]; m_int = wr_data[1:0];
                    end
                end
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            exp_rd = {4'b0000, m_en, m_mode, 2'(m_int)};
            vectors++;
            if (irq) irq_cnt++;
            if (wrst) rst_cnt++;
            if (rd_data !== exp_rd || irq !== m_irq || wrst !== m_rst) begin
                miscompares++;
                $display("FAIL %s: rd=%h irq=%b rst=%b expected rd=%h irq=%b rst=%b",
                         cur_req, rd_data, irq, wrst, exp_rd, m_irq, m_rst);
            end
        end
    end

    // Timebase tick: one cycle in every TDIV
    initial begin
        forever begin
            @(negedge clk);
            tick = (cyc % TDIV == TDIV - 1);
        end
    end

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc_wait(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic wait_evt(bit want_irq, int limit, output int t);
        t = -1;
        for (int i = 0; i < limit; i++) begin
            if (want_irq ? irq : wrst) begin t = cyc; break; end
            @(negedge clk);
        end
    endtask

    task automatic hard_reset();
        rst_n = 1'b0; sleep = 1'b0;
        cyc_wait(3);
        rst_n = 1'b1;
        cyc_wait(1);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int t1, t2, base_irq, base_rst, t_good, c;
        cyc_wait(4);
        // R1: reset state
        chk("R1 rd after reset", rd_data, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R1 rst after reset", wrst, 0);
        rst_n = 1'b1;
        @(negedge clk);
        wr(8'hA6);
        chk("R1 key field reads zero", rd_data, 8'h06);

        // R3: timer mode, tiny interval
        cur_req = "R3";
        base_rst = rst_cnt;
        wr(8'h0F);
        wait_evt(1, 200, t1);
        @(negedge clk);
        chk("R3 irq lasts one cycle", irq, 0);
        wait_evt(1, 200, t2);
        chk("R3 tiny period in cycles", t2 - t1, L_TINY * TDIV);

        // R2: every interval code
        cur_req = "R2";
        wr(8'h0E);
        wait_evt(1, 400, t1); @(negedge clk);
        wait_evt(1, 400, t2);
        chk("R2 code 10 period", t2 - t1, L_SHORT * TDIV);
        wr(8'h0D);
        wait_evt(1, 1200, t1); @(negedge clk);
        wait_evt(1, 1200, t2);
        chk("R2 code 01 period", t2 - t1, L_MID * TDIV);
        wr(8'h0C);
        wait_evt(1, 2200, t1); @(negedge clk);
        wait_evt(1, 2200, t2);
        chk("R2 code 00 period", t2 - t1, L_LONG * TDIV);

        // R4: stop in timer mode
        cur_req = "R4";
        wr(8'h07);
        base_irq = irq_cnt;
        cyc_wait(600);
        chk("R4 no irq after stop", irq_cnt - base_irq, 0);
        chk("R4 readback after stop", rd_data, 8'h07);
        chk("R12 no reset in timer mode", rst_cnt - base_rst, 0);

        hard_reset();
        base_irq = irq_cnt;

        // R6: watchdog lock
        cur_req = "R6";
        wr(8'h0B);
        chk("R6 watchdog enabled", rd_data, 8'h0B);
        wr(8'h07);
        chk("R6 mode and enable locked", rd_data, 8'h0B);
        wr(8'h02);
        chk("R6 interval still writable", rd_data, 8'h0A);
        wr(8'h0B);

        // R5: expiry
        cur_req = "R5";
        wait_evt(0, 200, t1);
        chk("R5 reset observed", (t1 >= 0) ? 1 : 0, 1);
        chk("R5 register cleared with pulse", rd_data, 0);
        @(negedge clk);
        chk("R5 reset lasts one cycle", wrst, 0);

        hard_reset();

        // R7: key clears postpone the reset
        cur_req = "R7";
        wr(8'h0B);
        base_rst = rst_cnt;
        repeat (6) begin
            cyc_wait(40);
            wr(8'hAB);
            wr(8'h5B);
        end
        cyc_wait(40);
        wr(8'hAB);
        cyc_wait(HALF - 1);
        wr(8'h5B);
        t_good = cyc;
        chk("R7 no reset while cleared", rst_cnt - base_rst, 0);

        // R8: void key sequences
        cur_req = "R8";
        cyc_wait(20);
        wr(8'hAB);
        cyc_wait(HALF);
        wr(8'h5B);
        wr(8'hAB);
        wr(8'h0B);
        wr(8'h5B);
        wr(8'h5B);
        wait_evt(0, 200, t1);
        chk("R8 reset not postponed", (t1 >= 0 && t1 <= t_good + L_TINY * TDIV) ? 1 : 0, 1);

        hard_reset();

        // R9: key inside the enabling write is ignored
        cur_req = "R9";
        while (cyc % TDIV != 2) @(negedge clk);
        c = cyc;
        wr(8'hAB);
        wr(8'h5B);
        wait_evt(0, 200, t1);
        chk("R9 enable-time key ignored", (t1 >= 0 && t1 - c <= 63) ? 1 : 0, 1);

        hard_reset();

        // R10: sleep withholds reset
        cur_req = "R10";
        wr(8'h0B);
        sleep = 1'b1;
        base_rst = rst_cnt;
        cyc_wait(300);
        chk("R10 no reset while asleep", rst_cnt - base_rst, 0);

        // R11: wake behaviour
        cur_req = "R11";
        for (int i = 0; i < 200 && !(m_nap && m_cnt == 5); i++) @(negedge clk);
        sleep = 1'b0;
        cyc_wait(2);
        chk("R11 early wake no reset", rst_cnt - base_rst, 0);
        sleep = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 200 && !(m_nap && m_cnt == L_TINY - 1); i++) @(negedge clk);
        sleep = 1'b0;
        @(negedge clk);
        chk("R11 wake in final period resets", wrst, 1);
        @(negedge clk);
        chk("R12 no irq in watchdog mode", irq_cnt - base_irq, 0);

        summary();
        $finish;
    end

endmodule